// File: doc/BRIEF.md
# E1 Transmit Overhead Multiplexer

This block assembles the outgoing E1 serial stream one bit at a time. An upstream counter presents the current frame number (0 to 15 within the multiframe) and the bit number (0 to 255 within the frame). For each position the block picks the output bit from one of five sources: the serial payload input, a stored time slot 0 byte, a stored time slot 16 signaling byte, a serial link input, or a constant one.

Each source is enabled by its own control input, and the controls follow a fixed order of precedence. The selected bit is registered, so it appears on the output one clock after its position is presented. A link strobe tells the upstream logic when to put the next Sa bit on the link input. CRC-4 computation, line coding and line drivers sit elsewhere. When the CRC or E bits travel in the first bit of time slot 0, they arrive on the serial payload input.

Top module: `e1_ovh_mux`

## Requirements
- R1: While `rst_n` is low, `tx_out` and `link_stb` read 0 at every clock edge, whatever the other inputs are.
- R2: The output is registered. The bit chosen for the position presented in cycle k appears on `tx_out` in cycle k+1. In time slots other than 0 and 16 (slot = `bit_idx[7:3]`), that bit is `ser_in`.
- R3: The bit within the slot is `bit_idx[2:0]`, where 0 is the first bit sent and maps to register bit 7. In bits 1 to 7 of time slot 0, the output comes from `fas_reg[7-b]` in even frames and from `nfas_reg[7-b]` in odd frames while `ctl_ts0_pass` is 0. It comes from `ser_in` while `ctl_ts0_pass` is 1.
- R4: Bit 0 of time slot 0 (the international bit) comes from bit 7 of the frame's time slot 0 register only when `ctl_si_reg` is 1 and `ctl_ts0_pass` is 0. In every other case it comes from `ser_in`.
- R5: In time slot 16 with `ctl_ts16_reg` set, the output is `sig_bytes[8*frame_idx + 7 - b]`. With `ctl_ts16_reg` clear, it is `ser_in`.
- R6: `ctl_sig_ones` forces every bit of time slot 16 to 1 in every frame. It takes precedence over `ctl_ts16_reg`.
- R7: In odd frames, bits 3 to 7 of time slot 0 are the Sa4 to Sa8 bits. Each has its own enable, `sa_link_en[b-3]`. When an enable is set, that bit comes from `link_in`, taking precedence over passthrough and the register. In even frames the enables have no effect.
- R8: `link_stb` is 1 in cycle k+1 exactly when the position presented in cycle k is the bit just before an enabled Sa bit. That position is an odd frame, time slot 0, b = 2 to 6, with `sa_link_en[b-2]` set. In every other case `link_stb` is 0.
- R9: `ctl_unf_ones` makes `tx_out` 1 at every position, framing included, taking precedence over all other controls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ser_in | input | 1 | Serial payload data for the current position |
| link_in | input | 1 | Serial link data for Sa bits |
| frame_idx | input | 4 | Frame number within the multiframe |
| bit_idx | input | 8 | Bit number within the frame |
| fas_reg | input | 8 | Time slot 0 contents for even frames |
| nfas_reg | input | 8 | Time slot 0 contents for odd frames |
| sig_bytes | input | 128 | Sixteen time slot 16 bytes, byte f at [8f+7:8f] |
| ctl_ts0_pass | input | 1 | Time slot 0 taken from `ser_in` |
| ctl_si_reg | input | 1 | International bit taken from register |
| ctl_ts16_reg | input | 1 | Time slot 16 taken from `sig_bytes` |
| ctl_sig_ones | input | 1 | Force time slot 16 to ones |
| ctl_unf_ones | input | 1 | Force the whole stream to ones |
| sa_link_en | input | 5 | Per-bit link enables for Sa4..Sa8 |
| tx_out | output | 1 | Multiplexed serial output |
| link_stb | output | 1 | Link strobe, one bit ahead of an enabled Sa bit |

## Verification
`ser_in` and `link_in` change at random on every bit, and the registers hold random values, so each output bit shows which source was actually picked. All 32 combinations of the five mode controls are run across a complete multiframe, with a different Sa enable pattern for each combination. This sets every pair of competing controls against each other, which exposes precedence errors. Separate short runs isolate the odd/even frame alternation in time slot 0, the per-frame choice of signaling byte, and the strobe placement for sparse Sa enable patterns.

// File: rtl/e1_ovh_mux.sv
module e1_ovh_mux #(
  parameter int FRAMES    = 16,
  parameter int SLOTS     = 32,
  parameter int SLOT_BITS = 8,
  parameter int NSA       = 5,
  parameter int SA_FIRST  = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          ser_in,
  input  logic                          link_in,
  input  logic [$clog2(FRAMES)-1:0]     frame_idx,
  input  logic [$clog2(SLOTS*SLOT_BITS)-1:0] bit_idx,
  input  logic [SLOT_BITS-1:0]          fas_reg,
  input  logic [SLOT_BITS-1:0]          nfas_reg,
  input  logic [FRAMES*SLOT_BITS-1:0]   sig_bytes,
  input  logic                          ctl_ts0_pass,
  input  logic                          ctl_si_reg,
  input  logic                          ctl_ts16_reg,
  input  logic                          ctl_sig_ones,
  input  logic                          ctl_unf_ones,
  input  logic [NSA-1:0]                sa_link_en,
  output logic                          tx_out,
  output logic                          link_stb
);
  localparam int FW = $clog2(FRAMES);
  localparam int BW = $clog2(SLOTS*SLOT_BITS);
  localparam int SW = $clog2(SLOT_BITS);
  localparam int TW = BW - SW;
  localparam logic [TW-1:0] SIG_SLOT = TW'(SLOTS/2);

  logic [TW-1:0]    slot;
  logic [SW-1:0]    pos;
  logic             odd, in_ts0, in_ts16;
  logic [SLOT_BITS-1:0] ts0_byte, sa_map;
  logic [FW+SW-1:0] sig_ix;
  logic             sa_on, stb_nxt, nxt;

  assign slot     = bit_idx[BW-1:SW];
  assign pos      = bit_idx[SW-1:0];
  assign odd      = frame_idx[0];
  assign in_ts0   = (slot == '0);
  assign in_ts16  = (slot == SIG_SLOT);
  assign ts0_byte = odd ? nfas_reg : fas_reg;
  assign sig_ix   = {frame_idx, ~pos};

  for (genvar i = 0; i < SLOT_BITS; i++) begin : g_sa
    if (i >= SA_FIRST && i < SA_FIRST + NSA) begin : g_on
      assign sa_map[i] = sa_link_en[i-SA_FIRST];
    end else begin : g_off
      assign sa_map[i] = 1'b0;
    end
  end

  assign sa_on   = odd && in_ts0 && sa_map[pos];
  assign stb_nxt = odd && in_ts0 && sa_map[pos + SW'(1)] && (pos != SW'(SLOT_BITS-1));

  always_comb begin
    nxt = ser_in;
    if (in_ts0) begin
      if (pos == '0) nxt = (ctl_si_reg && !ctl_ts0_pass) ? ts0_byte[SLOT_BITS-1] : ser_in;
      else           nxt = ctl_ts0_pass ? ser_in : ts0_byte[~pos];
      if (sa_on) nxt = link_in;
    end else if (in_ts16) begin
      if (ctl_sig_ones)      nxt = 1'b1;
      else if (ctl_ts16_reg) nxt = sig_bytes[sig_ix];
    end
    if (ctl_unf_ones) nxt = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_out   <= 1'b0;
      link_stb <= 1'b0;
    end else begin
      tx_out   <= nxt;
      link_stb <= stb_nxt;
    end
  end

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (!tx_out && !link_stb));

  a_r9_unframed_ones: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_unf_ones |=> tx_out);

  a_r6_sig_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ts16 && ctl_sig_ones) |=> tx_out);

  a_r2_payload: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ts0 && !in_ts16 && !ctl_unf_ones) |=> (tx_out == $past(ser_in)));

  a_r7_link_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (sa_on && !ctl_unf_ones) |=> (tx_out == $past(link_in)));

  a_r8_stb_even_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!odd || !in_ts0) |=> !link_stb);
endmodule

// File: tb/e1_ovh_mux_tb_top.sv
module e1_ovh_mux_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ser_in, link_in;
  logic [3:0]  frame_idx;
  logic [7:0]  bit_idx;
  logic [7:0]  fas_reg, nfas_reg;
  logic [127:0] sig_bytes;
  logic        ctl_ts0_pass, ctl_si_reg, ctl_ts16_reg, ctl_sig_ones, ctl_unf_ones;
  logic [4:0]  sa_link_en;
  logic        tx_out, link_stb;

  int n_chk = 0, n_bad = 0;
  logic pend = 1'b0;
  logic exp_tx, exp_stb;
  string exp_tag;
  logic [7:0] sig_arr [16];

  always #10 clk = ~clk;

  e1_ovh_mux dut_i (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .link_in(link_in),
    .frame_idx(frame_idx), .bit_idx(bit_idx), .fas_reg(fas_reg), .nfas_reg(nfas_reg),
    .sig_bytes(sig_bytes), .ctl_ts0_pass(ctl_ts0_pass), .ctl_si_reg(ctl_si_reg),
    .ctl_ts16_reg(ctl_ts16_reg), .ctl_sig_ones(ctl_sig_ones), .ctl_unf_ones(ctl_unf_ones),
    .sa_link_en(sa_link_en), .tx_out(tx_out), .link_stb(link_stb)
  );

  always_comb for (int f = 0; f < 16; f++) sig_bytes[f*8 +: 8] = sig_arr[f];

  function automatic logic model_tx(int fr, int bi);
    int ts = bi / 8;
    int b  = bi % 8;
    logic [7:0] r;
    if (ctl_unf_ones) return 1'b1;
    if (ts == 16) begin
      if (ctl_sig_ones) return 1'b1;
      if (ctl_ts16_reg) return sig_arr[fr][7-b];
      return ser_in;
    end
    if (ts != 0) return ser_in;
    if ((fr % 2) == 1 && b >= 3 && sa_link_en[b-3]) return link_in;
    r = ((fr % 2) == 1) ? nfas_reg : fas_reg;
    if (b == 0) return (ctl_si_reg && !ctl_ts0_pass) ? r[7] : ser_in;
    return ctl_ts0_pass ? ser_in : r[7-b];
  endfunction

  function automatic string model_tag(int fr, int bi);
    int ts = bi / 8;
    int b  = bi % 8;
    if (ctl_unf_ones) return "R9";
    if (ts == 16) return ctl_sig_ones ? "R6" : "R5";
    if (ts != 0) return "R2";
    if ((fr % 2) == 1 && b >= 3 && sa_link_en[b-3]) return "R7";
    if (b == 0) return "R4";
    return "R3";
  endfunction

  function automatic logic model_stb(int fr, int bi);
    int b = bi % 8;
    return (fr % 2) == 1 && (bi / 8) == 0 && b >= 2 && b <= 6 && sa_link_en[b-2];
  endfunction

  task automatic compare(string tag, logic act, logic exp, string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
    end
  endtask

  task automatic flush();
    @(negedge clk);
    if (pend) begin
      compare(exp_tag, tx_out, exp_tx, "tx_out");
      compare("R8", link_stb, exp_stb, "link_stb");
    end
    pend = 1'b0;
  endtask

  task automatic step(int fr, int bi);
    flush();
    frame_idx = 4'(fr);
    bit_idx   = 8'(bi);
    ser_in    = 1'($urandom);
    link_in   = 1'($urandom);
    exp_tx  = model_tx(fr, bi);
    exp_stb = model_stb(fr, bi);
    exp_tag = model_tag(fr, bi);
    pend = 1'b1;
  endtask

  task automatic set_mode(logic [4:0] md, logic [4:0] sa);
    {ctl_unf_ones, ctl_sig_ones, ctl_ts16_reg, ctl_si_reg, ctl_ts0_pass} = md;
    sa_link_en = sa;
  endtask

  task automatic run_frames(int f0, int nf);
    for (int f = f0; f < f0 + nf; f++)
      for (int bi = 0; bi < 256; bi++) step(f % 16, bi);
    flush();
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    set_mode(5'b10000, 5'b11111);
    frame_idx = 4'd1; bit_idx = 8'd2; ser_in = 1'b1; link_in = 1'b1;
    repeat (3) @(negedge clk);
    compare("R1", tx_out, 1'b0, "tx_out in reset");
    compare("R1", link_stb, 1'b0, "link_stb in reset");
    rst_n = 1'b1;
  endtask

  task automatic t_payload();
    set_mode(5'b00000, 5'b00000);
    run_frames(2, 2);
  endtask

  task automatic t_ts0();
    set_mode(5'b00000, 5'b00000); run_frames(0, 2);
    set_mode(5'b00001, 5'b00000); run_frames(4, 2);
  endtask

  task automatic t_si();
    set_mode(5'b00010, 5'b00000); run_frames(6, 2);
    set_mode(5'b00011, 5'b00000); run_frames(8, 2);
  endtask

  task automatic t_ts16();
    set_mode(5'b00100, 5'b00000); run_frames(0, 16);
  endtask

  task automatic t_sig_ones();
    set_mode(5'b01100, 5'b00000); run_frames(10, 2);
  endtask

  task automatic t_link();
    set_mode(5'b00001, 5'b00001); run_frames(0, 2);
    set_mode(5'b00000, 5'b10000); run_frames(2, 2);
    set_mode(5'b00010, 5'b01010); run_frames(4, 2);
    set_mode(5'b00000, 5'b11111); run_frames(6, 2);
  endtask

  task automatic t_unf();
    set_mode(5'b11111, 5'b11111); run_frames(12, 2);
  endtask

  task automatic t_sweep();
    for (int c = 0; c < 32; c++) begin
      set_mode(5'(c), 5'(c) ^ 5'b10101);
      run_frames(0, 16);
    end
  endtask

  initial begin
    fas_reg  = 8'h9B;
    nfas_reg = 8'h5D;
    for (int f = 0; f < 16; f++) sig_arr[f] = 8'($urandom);
    t_reset();
    t_payload();
    t_ts0();
    t_si();
    t_ts16();
    t_sig_ones();
    t_link();
    t_unf();
    t_sweep();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule